// File: doc/BRIEF.md
# Output Phase Step Controller

This block keeps one signed phase offset per clock output, counted in 20 ps units, and moves it by a programmed step each time an increment or decrement command arrives. Commands come from two sources. The first is a register command port that names an output and a direction. The second is a pair of pulse inputs, one raising and one lowering the phase, both wired to a single fixed output. Pulse inputs are resynchronised and edge-detected, so a pulse of any length gives exactly one step. A pulse is held pending until it is served, so a register command in the same cycle never loses it.

Every offset is kept inside ±2250 units, which is ±45 ns. A command that would pass the limit leaves the offset at the limit and raises a reject pulse. A decrement shortens one half cycle of the generated clock. It is refused with the offset left unchanged when the output's current half period, minus the step, would fall below four VCO periods. On reset and on a synchronous soft reset, each output whose R divider is 1 loads its configured initial offset, clamped to the range. Every other output loads zero.

Top module: `phs_step_ctrl`

## Requirements
- R1: A register command with `cmd_inc`=1 adds `step_size` to the offset of output `cmd_sel`; the new value is on `phase_ofs` after the next clock edge, and all other offsets stay unchanged.
- R2: A register command with `cmd_inc`=0 subtracts `step_size` from the selected offset on the next edge when the decrement is allowed.
- R3: A result above +2250 or below -2250 is stored as +2250 or -2250, and `reject` is 1 for the following cycle.
- R4: A decrement is refused when half period minus step is less than 4×`vco_per`; the offset is unchanged and `reject` pulses. A result exactly equal to 4×`vco_per` is allowed.
- R5: Each rising edge on `pin_inc` or `pin_dec` gives exactly one step on output PIN_OUT, whatever the pulse length. It takes effect on the fourth clock edge, counting the first edge that samples the pin high as the first.
- R6: A register command wins over a pending pin step in the same cycle; the pin step is applied one edge later. When both pin directions are pending, the increment is served first.
- R7: While `rst_n` is low at a clock edge (synchronous reset), each offset loads its initial value if its `r_is_one` bit is 1, else 0; `reject` is 0.
- R8: `soft_rst` high at an edge performs the same load as R7 and overrides any command in that cycle.
- R9: `reject` is a one-cycle pulse that follows only a refused or saturated command; otherwise it is 0.
- R10: An initial offset outside ±2250 is loaded clamped to the limit, without a reject pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| soft_rst | input | 1 | Reload initial offsets on the next edge |
| cmd_valid | input | 1 | Register command present this cycle |
| cmd_inc | input | 1 | 1 raises the phase, 0 lowers it |
| cmd_sel | input | SEL_W | Output addressed by the register command |
| step_size | input | STEP_W | Step in 20 ps units, unsigned |
| pin_inc | input | 1 | Asynchronous raise pulse for output PIN_OUT |
| pin_dec | input | 1 | Asynchronous lower pulse for output PIN_OUT |
| half_per | input | N_OUT*PER_W | Current half period of each output, 20 ps units, output i at bits [i*PER_W +: PER_W] |
| vco_per | input | VCO_W | VCO period in 20 ps units |
| init_ofs | input | N_OUT*OFS_W | Signed initial offset of each output |
| r_is_one | input | N_OUT | Bit i is 1 when output i has R divider 1 |
| phase_ofs | output | N_OUT*OFS_W | Signed offset of each output, 20 ps units |
| reject | output | 1 | One-cycle pulse after a refused or saturated command |

## Verification
A register command or a soft reset shows on `phase_ofs` and `reject` after exactly one edge. A pin pulse shows after its fourth edge, or one edge later when a register command takes that slot. The bench drives stimulus at the falling edge and keeps a behavioural model. For each pin pulse the model queues the edge number on which the step is due, and moves it by one edge when a register command collides with it. After every rising edge the model and the ports are compared at the next falling edge, so each result is checked in the cycle it is due and in every cycle after it.

// File: rtl/phs_pkg.sv
package phs_pkg;
    // +-45 ns expressed in 20 ps units
    localparam int PHS_LIMIT = 2250;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_INC  = 2'd1,
        OP_DEC  = 2'd2
    } phs_op_e;
endpackage

// File: rtl/phs_pin_sync.sv
module phs_pin_sync #(
    parameter int NPIN = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NPIN-1:0] pin_i,
    output logic [NPIN-1:0] rise_o
);
    typedef struct packed {
        logic [NPIN-1:0] s1;
        logic [NPIN-1:0] s2;
        logic [NPIN-1:0] s3;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = pin_i;
        st_d.s2 = st_q.s1;
        st_d.s3 = st_q.s2;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_edge
        assign rise_o[g] = st_q.s2[g] & ~st_q.s3[g];

        // R5: a detected edge lasts one cycle, so a long pulse cannot step twice
        p_one_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> !rise_o[g]);
    end
endmodule

// File: rtl/phs_step_alu.sv
module phs_step_alu
    import phs_pkg::*;
#(
    parameter int OFS_W  = 13,
    parameter int STEP_W = 12,
    parameter int PER_W  = 16,
    parameter int VCO_W  = 10
) (
    input  phs_op_e           op_i,
    input  logic [OFS_W-1:0]  cur_i,
    input  logic [STEP_W-1:0] step_i,
    input  logic [PER_W-1:0]  hp_i,
    input  logic [VCO_W-1:0]  vco_i,
    output logic [OFS_W-1:0]  nxt_o,
    output logic              rej_o
);
    localparam int A = (OFS_W > STEP_W) ? OFS_W : STEP_W;
    localparam int B = (PER_W > VCO_W + 2) ? PER_W : VCO_W + 2;
    localparam int W = ((A > B) ? A : B) + 2;
    localparam logic signed [W-1:0] LIM = W'(PHS_LIMIT);

    logic signed [W-1:0] cur_x, step_x, hp_x, min_x, res_x;

    always_comb begin
        cur_x  = W'($signed(cur_i));
        step_x = W'(step_i);
        hp_x   = W'(hp_i);
        min_x  = W'({vco_i, 2'b00});
        res_x  = cur_x;
        rej_o  = 1'b0;
        case (op_i)
            OP_INC: begin
                res_x = cur_x + step_x;
                if (res_x > LIM) begin
                    res_x = LIM;
                    rej_o = 1'b1;
                end
            end
            OP_DEC: begin
                if (hp_x - step_x < min_x) begin
                    rej_o = 1'b1;
                end else begin
                    res_x = cur_x - step_x;
                    if (res_x < -LIM) begin
                        res_x = -LIM;
                        rej_o = 1'b1;
                    end
                end
            end
            default: ;
        endcase
        nxt_o = res_x[OFS_W-1:0];
    end
endmodule

// File: rtl/phs_step_ctrl.sv
module phs_step_ctrl
    import phs_pkg::*;
#(
    parameter int N_OUT   = 4,
    parameter int OFS_W   = 13,
    parameter int STEP_W  = 12,
    parameter int PER_W   = 16,
    parameter int VCO_W   = 10,
    parameter int PIN_OUT = 0,
    localparam int SEL_W  = (N_OUT > 1) ? $clog2(N_OUT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    soft_rst,
    input  logic                    cmd_valid,
    input  logic                    cmd_inc,
    input  logic [SEL_W-1:0]        cmd_sel,
    input  logic [STEP_W-1:0]       step_size,
    input  logic                    pin_inc,
    input  logic                    pin_dec,
    input  logic [N_OUT*PER_W-1:0]  half_per,
    input  logic [VCO_W-1:0]        vco_per,
    input  logic [N_OUT*OFS_W-1:0]  init_ofs,
    input  logic [N_OUT-1:0]        r_is_one,
    output logic [N_OUT*OFS_W-1:0]  phase_ofs,
    output logic                    reject
);
    localparam logic signed [OFS_W-1:0] LIM_O = OFS_W'(PHS_LIMIT);

    typedef struct packed {
        logic [N_OUT-1:0][OFS_W-1:0] ofs;
        logic                        rej;
        logic [1:0]                  pend;   // [0] raise, [1] lower
    } st_t;

    st_t st_d, st_q;

    logic [1:0]                  rise;
    logic [N_OUT-1:0][OFS_W-1:0] init_load;
    phs_op_e                     op;
    logic [SEL_W-1:0]            sel;
    logic [1:0]                  served;
    logic [OFS_W-1:0]            alu_nxt;
    logic                        alu_rej;

    phs_pin_sync #(.NPIN(2)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({pin_dec, pin_inc}),
        .rise_o (rise)
    );

    // initial offsets, clamped, gated by the divider setting
    always_comb begin
        for (int i = 0; i < N_OUT; i++) begin
            logic signed [OFS_W-1:0] v;
            v = $signed(init_ofs[i*OFS_W +: OFS_W]);
            if (v > LIM_O)       v = LIM_O;
            else if (v < -LIM_O) v = -LIM_O;
            init_load[i] = r_is_one[i] ? v : '0;
        end
    end

    // command arbitration: register port, then pending raise, then lower
    always_comb begin
        op     = OP_NONE;
        sel    = SEL_W'(PIN_OUT);
        served = 2'b00;
        if (cmd_valid && (int'(cmd_sel) < N_OUT)) begin
            op  = cmd_inc ? OP_INC : OP_DEC;
            sel = cmd_sel;
        end else if (st_q.pend[0]) begin
            op        = OP_INC;
            served[0] = 1'b1;
        end else if (st_q.pend[1]) begin
            op        = OP_DEC;
            served[1] = 1'b1;
        end
    end

    phs_step_alu #(
        .OFS_W  (OFS_W),
        .STEP_W (STEP_W),
        .PER_W  (PER_W),
        .VCO_W  (VCO_W)
    ) i_alu (
        .op_i   (op),
        .cur_i  (st_q.ofs[sel]),
        .step_i (step_size),
        .hp_i   (half_per[sel*PER_W +: PER_W]),
        .vco_i  (vco_per),
        .nxt_o  (alu_nxt),
        .rej_o  (alu_rej)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rej = 1'b0;
        if (soft_rst) begin
            st_d.ofs  = init_load;
            st_d.pend = st_q.pend | rise;
        end else begin
            st_d.pend = (st_q.pend & ~served) | rise;
            if (op != OP_NONE) begin
                st_d.ofs[sel] = alu_nxt;
                st_d.rej      = alu_rej;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ofs  <= init_load;
            st_q.rej  <= 1'b0;
            st_q.pend <= 2'b00;
        end else begin
            st_q <= st_d;
        end
    end

    assign phase_ofs = st_q.ofs;
    assign reject    = st_q.rej;

    // ---------------- assertions ----------------
    for (genvar g = 0; g < N_OUT; g++) begin : g_chk
        p_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (int'($signed(st_q.ofs[g])) <= PHS_LIMIT) &&
            (int'($signed(st_q.ofs[g])) >= -PHS_LIMIT));

        p_step_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && !soft_rst && cmd_sel == SEL_W'(g)) |=>
            ((int'($signed(st_q.ofs[g])) - int'($signed($past(st_q.ofs[g]))) <= int'($past(step_size))) &&
             (int'($signed($past(st_q.ofs[g]))) - int'($signed(st_q.ofs[g])) <= int'($past(step_size)))));

        p_short_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid && !cmd_inc && !soft_rst && cmd_sel == SEL_W'(g) &&
             (int'(half_per[g*PER_W +: PER_W]) - int'(step_size) < 4 * int'(vco_per)))
            |=> (reject && $stable(st_q.ofs[g])));
    end

    p_reject_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
        reject |-> $past(cmd_valid || (st_q.pend != 2'b00)));

    p_idle_stable_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_valid && !soft_rst && st_q.pend == 2'b00) |=> $stable(st_q.ofs));
endmodule

// File: tb/test_phs_step_ctrl.sv
module test_phs_step_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int N = 4;
    localparam int OW = 13;
    localparam int PW = 16;
    localparam int LIM = 2250;
    localparam int PIN = 0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic soft_rst = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_inc = 1'b0;
    logic [1:0] cmd_sel = '0;
    logic [11:0] step_size = '0;
    logic pin_inc = 1'b0;
    logic pin_dec = 1'b0;
    logic [N*PW-1:0] half_per;
    logic [9:0] vco_per = 10'd100;
    logic [N*OW-1:0] init_ofs;
    logic [N-1:0] r_is_one = 4'b1101;
    logic [N*OW-1:0] phase_ofs;
    logic reject;

    int bhp[N] = '{20000, 20000, 20000, 20000};
    int binit[N] = '{100, 500, -3000, -40};

    always_comb begin
        for (int i = 0; i < N; i++) begin
            half_per[i*PW +: PW] = PW'(bhp[i]);
            init_ofs[i*OW +: OW] = OW'(binit[i]);
        end
    end

    always #(CLK_PERIOD/2) clk = ~clk;

    phs_step_ctrl i_phs_step_ctrl (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .cmd_valid(cmd_valid), .cmd_inc(cmd_inc), .cmd_sel(cmd_sel),
        .step_size(step_size), .pin_inc(pin_inc), .pin_dec(pin_dec),
        .half_per(half_per), .vco_per(vco_per), .init_ofs(init_ofs),
        .r_is_one(r_is_one), .phase_ofs(phase_ofs), .reject(reject)
    );

    int total = 0;
    int fails = 0;
    string cur_req = "R7";
    int m_ofs[N];
    int nx[N];
    int m_rej = 0;
    int nrej = 0;
    int cyc = 0;
    int inc_due = -1;
    int dec_due = -1;

    function automatic int clampv(int v);
        if (v > LIM) return LIM;
        if (v < -LIM) return -LIM;
        return v;
    endfunction

    function automatic void mload();
        for (int i = 0; i < N; i++) nx[i] = r_is_one[i] ? clampv(binit[i]) : 0;
    endfunction

    function automatic void mapply(int ch, bit up);
        int s = int'(step_size);
        if (up) begin
            if (m_ofs[ch] + s > LIM) begin nx[ch] = LIM; nrej = 1; end
            else nx[ch] = m_ofs[ch] + s;
        end else if (bhp[ch] - s < 4 * int'(vco_per)) begin
            nrej = 1;
        end else if (m_ofs[ch] - s < -LIM) begin
            nx[ch] = -LIM; nrej = 1;
        end else begin
            nx[ch] = m_ofs[ch] - s;
        end
    endfunction

    task automatic chk(string what, int act, int exp);
        total++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", cur_req, what, act, exp);
        end
    endtask

    // one clock: model next state from driven inputs, then compare at negedge
    task automatic tick();
        int e = cyc + 1;
        nx = m_ofs;
        nrej = 0;
        if (!rst_n || soft_rst) begin
            mload();
        end else if (cmd_valid) begin
            mapply(int'(cmd_sel), cmd_inc);
            if (inc_due == e) inc_due++;
            if (dec_due == e) dec_due++;
        end else if (inc_due == e) begin
            mapply(PIN, 1'b1); inc_due = -1;
        end else if (dec_due == e) begin
            mapply(PIN, 1'b0); dec_due = -1;
        end
        @(posedge clk);
        cyc++;
        m_ofs = nx;
        m_rej = nrej;
        @(negedge clk);
        for (int i = 0; i < N; i++)
            chk($sformatf("ofs%0d", i), int'($signed(phase_ofs[i*OW +: OW])), m_ofs[i]);
        chk("reject", int'(reject), m_rej);
    endtask

    task automatic cmd(bit up, int ch, int step);
        cmd_valid = 1'b1; cmd_inc = up; cmd_sel = 2'(ch); step_size = 12'(step);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic pulse(bit up, int len);
        if (up) begin pin_inc = 1'b1; inc_due = cyc + 4; end
        else    begin pin_dec = 1'b1; dec_due = cyc + 4; end
        for (int k = 0; k < len; k++) tick();
        pin_inc = 1'b0; pin_dec = 1'b0;
        for (int k = 0; k < 6; k++) tick();
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++; total++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R7, R10: reset load with gating and clamping
        cur_req = "R7_R10";
        for (int k = 0; k < 3; k++) tick();
        rst_n = 1'b1;
        tick();
        chk("R10 clamp ofs2", int'($signed(phase_ofs[2*OW +: OW])), -LIM);
        chk("R7 gated ofs1", int'($signed(phase_ofs[1*OW +: OW])), 0);
        // R1, R2
        cur_req = "R1"; cmd(1'b1, 1, 50); tick(); cmd(1'b1, 3, 7);
        cur_req = "R2"; cmd(1'b0, 0, 30); cmd(1'b0, 3, 1000);
        // R3 saturation both ways
        cur_req = "R3"; cmd(1'b1, 1, 3000); tick();
        cmd(1'b0, 1, 3000); cmd(1'b0, 1, 3000); tick();
        // R4 half-cycle guard: hp 500, 4*vco 400
        cur_req = "R4"; bhp[2] = 500; step_size = 0; tick();
        cmd(1'b1, 2, 2000); cmd(1'b0, 2, 101); cmd(1'b0, 2, 100); tick();
        // R5 pins, long and short pulses
        cur_req = "R5"; step_size = 12'd25;
        pulse(1'b1, 7); pulse(1'b0, 1); pulse(1'b1, 1);
        // R6 collision: register command on the pin's due edge
        cur_req = "R6";
        pin_inc = 1'b1; inc_due = cyc + 4;
        tick(); tick(); tick();
        cmd(1'b0, 3, 25);
        pin_inc = 1'b0;
        for (int k = 0; k < 5; k++) tick();
        // R6 both pins pending: raise first, lower next
        step_size = 12'd10;
        pin_inc = 1'b1; pin_dec = 1'b1; inc_due = cyc + 4; dec_due = cyc + 5;
        tick(); pin_inc = 1'b0; pin_dec = 1'b0;
        for (int k = 0; k < 6; k++) tick();
        // R8 soft reset overrides a command
        cur_req = "R8"; binit[1] = 700; r_is_one = 4'b1111;
        soft_rst = 1'b1; cmd(1'b1, 1, 5); soft_rst = 1'b0;
        chk("R8 ofs1 reload", int'($signed(phase_ofs[1*OW +: OW])), 700);
        // R9 idle: no reject without commands
        cur_req = "R9";
        for (int k = 0; k < 4; k++) tick();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule